// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the operating mode of a small microcontroller. There are three running modes: full-speed active, medium-speed active and subclock-active. There are four halted modes: sleep, subsleep, standby and watch. A one-cycle strobe signals that the core has executed its sleep instruction, and a wake input signals an interrupt or another wake source. A small control register, loaded through a plain write port, holds the flags that choose where each event leads.

With the direct-transfer flag clear, a sleep strobe always halts the core. With the flag set, one sleep strobe can instead move the core straight from one running mode to another. The flag combination decides which running mode is chosen. When no direct rule matches, the ordinary halting choice applies. The block also produces a clock-select code and a halted flag for the clock generator. It passes the noise-filter sampling choice straight out as a register bit.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (full-speed active), `clk_sel_o` is 0, `halted_o` is 0, `nfilt_fast_o` is 0 and every control bit is 0.
- R2: In either active mode, a sleep strobe that is not taken by a direct rule halts the core. The target depends on `deep_en` and `wtimer_en`: `deep_en`=0 gives sleep (3); `deep_en`=1 with `wtimer_en`=0 gives standby (5); `deep_en`=1 with `wtimer_en`=1 gives watch (6).
- R3: In subclock-active (2), a sleep strobe that is not taken by a direct rule gives subsleep (4) when `deep_en`=0 and watch (6) when `deep_en`=1.
- R4: With `direct_en`=1 in full-speed active (0), a sleep strobe with `deep_en`=0, `med_en`=1 and `sub_en`=0 moves to medium-speed active (1).
- R5: With `direct_en`=1 in medium-speed active (1), a sleep strobe with `deep_en`=0, `med_en`=0 and `sub_en`=0 moves to full-speed active (0).
- R6: With `direct_en`=1 in either active mode, a sleep strobe with `deep_en`=1, `wtimer_en`=1 and `sub_en`=1 moves to subclock-active (2).
- R7: With `direct_en`=1 in subclock-active, a sleep strobe with `deep_en`=1, `wtimer_en`=1 and `sub_en`=0 moves to mode 1 when `med_en`=1 and to mode 0 when `med_en`=0.
- R8: When `direct_en`=1 and the flags match none of the rules R4 to R7, the sleep strobe behaves as in R2 or R3.
- R9: A wake event in sleep or standby resumes medium-speed active (1) when `med_en`=1 and full-speed active (0) when `med_en`=0.
- R10: A wake event in subsleep resumes subclock-active. A wake event in watch resumes subclock-active when `sub_en`=1; otherwise it follows the `med_en` choice of R9.
- R11: Mode codes are 0 full, 1 medium, 2 subclock-active, 3 sleep, 4 subsleep, 5 standby, 6 watch. `clk_sel_o` is 0 in modes 0 and 3, 1 in mode 1, 2 in modes 2, 4 and 6, and 3 in mode 5. `halted_o` is 1 exactly in modes 3 to 6.
- R12: A sleep strobe is ignored while the core is halted. A wake event is ignored while the core is running. When both arrive in a running mode, the sleep strobe is acted on.
- R13: The control byte layout is: bit 0 `deep_en`, bit 1 `sub_en`, bit 2 `med_en`, bit 3 `wtimer_en`, bit 4 `direct_en`, bit 5 noise-filter fast sampling (0 = oscillator/16, 1 = oscillator/4, shown on `nfilt_fast_o`). A write takes effect on the following cycle, so a sleep strobe in the same cycle as a write uses the old bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 6 | Control register write data |
| sleep_i | input | 1 | One-cycle sleep-instruction strobe |
| wake_i | input | 1 | Wake / interrupt request |
| mode_o | output | 3 | Current operating mode code |
| clk_sel_o | output | 2 | Clock-source select code |
| halted_o | output | 1 | Core halted flag |
| nfilt_fast_o | output | 1 | Noise-filter sampling select bit |

## Verification
A sleep strobe or wake event applied before a clock edge changes `mode_o` at that edge. `clk_sel_o` and `halted_o` follow in the same cycle, because they are decoded from the mode register. A register write changes the flags, and `nfilt_fast_o`, one edge later. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge. It then compares all four outputs on the next falling edge, so every result is checked in the first cycle it is due. Sequences include writes made in the same cycle as a strobe, strobes while halted, and wakes while running, so any off-by-one in the way flags are applied shows up as a mismatch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;
    localparam int CSEL_W = 2;
    localparam int CFG_W  = 6;

    typedef enum logic [MODE_W-1:0] {
        M_ACT_HI   = 3'd0,
        M_ACT_MED  = 3'd1,
        M_SUBACT   = 3'd2,
        M_SLEEP    = 3'd3,
        M_SUBSLEEP = 3'd4,
        M_STANDBY  = 3'd5,
        M_WATCH    = 3'd6
    } lpm_mode_e;

    // control byte, bit 0 at the bottom
    typedef struct packed {
        logic nfilt_fast;
        logic direct_en;
        logic wtimer_en;
        logic med_en;
        logic sub_en;
        logic deep_en;
    } lpm_cfg_t;

    localparam logic [CSEL_W-1:0] CSEL_FULL = 2'd0;
    localparam logic [CSEL_W-1:0] CSEL_DIV  = 2'd1;
    localparam logic [CSEL_W-1:0] CSEL_SUB  = 2'd2;
    localparam logic [CSEL_W-1:0] CSEL_OFF  = 2'd3;

    typedef struct packed {
        lpm_mode_e mode;
    } lpm_state_t;

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
    import lpm_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output lpm_cfg_t     cfg_o
);

    lpm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = lpm_cfg_t'(wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/lpm_next_mode.sv
module lpm_next_mode
    import lpm_pkg::*;
(
    input  lpm_mode_e cur_i,
    input  logic      sleep_i,
    input  logic      wake_i,
    input  lpm_cfg_t  cfg_i,
    output lpm_mode_e nxt_o
);

    lpm_mode_e resume_act;   // active mode picked by the speed flag
    lpm_mode_e halt_act;     // halted target from an active mode
    lpm_mode_e halt_sub;     // halted target from subclock-active
    logic      dir_hi_med;
    logic      dir_med_hi;
    logic      dir_to_sub;
    logic      dir_from_sub;

    always_comb begin
        resume_act   = cfg_i.med_en ? M_ACT_MED : M_ACT_HI;
        halt_act     = !cfg_i.deep_en ? M_SLEEP
                     : (cfg_i.wtimer_en ? M_WATCH : M_STANDBY);
        halt_sub     = cfg_i.deep_en ? M_WATCH : M_SUBSLEEP;

        dir_hi_med   = cfg_i.direct_en && !cfg_i.deep_en && cfg_i.med_en  && !cfg_i.sub_en;
        dir_med_hi   = cfg_i.direct_en && !cfg_i.deep_en && !cfg_i.med_en && !cfg_i.sub_en;
        dir_to_sub   = cfg_i.direct_en && cfg_i.deep_en && cfg_i.wtimer_en && cfg_i.sub_en;
        dir_from_sub = cfg_i.direct_en && cfg_i.deep_en && cfg_i.wtimer_en && !cfg_i.sub_en;

        nxt_o = cur_i;
        unique case (cur_i)
            M_ACT_HI: begin
                if (sleep_i) begin
                    if (dir_hi_med)      nxt_o = M_ACT_MED;
                    else if (dir_to_sub) nxt_o = M_SUBACT;
                    else                 nxt_o = halt_act;
                end
            end
            M_ACT_MED: begin
                if (sleep_i) begin
                    if (dir_med_hi)      nxt_o = M_ACT_HI;
                    else if (dir_to_sub) nxt_o = M_SUBACT;
                    else                 nxt_o = halt_act;
                end
            end
            M_SUBACT: begin
                if (sleep_i) begin
                    nxt_o = dir_from_sub ? resume_act : halt_sub;
                end
            end
            M_SLEEP, M_STANDBY: begin
                if (wake_i) nxt_o = resume_act;
            end
            M_SUBSLEEP: begin
                if (wake_i) nxt_o = M_SUBACT;
            end
            M_WATCH: begin
                if (wake_i) nxt_o = cfg_i.sub_en ? M_SUBACT : resume_act;
            end
            default: nxt_o = M_ACT_HI;
        endcase
    end

endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
    import lpm_pkg::*;
(
    input  lpm_mode_e         mode_i,
    output logic [CSEL_W-1:0] clk_sel_o,
    output logic              halted_o
);

    always_comb begin
        clk_sel_o = CSEL_FULL;
        halted_o  = 1'b0;
        unique case (mode_i)
            M_ACT_HI:   clk_sel_o = CSEL_FULL;
            M_ACT_MED:  clk_sel_o = CSEL_DIV;
            M_SUBACT:   clk_sel_o = CSEL_SUB;
            M_SLEEP: begin
                clk_sel_o = CSEL_FULL;
                halted_o  = 1'b1;
            end
            M_SUBSLEEP, M_WATCH: begin
                clk_sel_o = CSEL_SUB;
                halted_o  = 1'b1;
            end
            M_STANDBY: begin
                clk_sel_o = CSEL_OFF;
                halted_o  = 1'b1;
            end
            default: begin
                clk_sel_o = CSEL_FULL;
                halted_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
    import lpm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              sleep_i,
    input  logic              wake_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CSEL_W-1:0] clk_sel_o,
    output logic              halted_o,
    output logic              nfilt_fast_o
);

    lpm_cfg_t   cfg_q;
    lpm_mode_e  nxt_mode;
    lpm_state_t st_d, st_q;

    lpm_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_q)
    );

    lpm_next_mode u_next (
        .cur_i   (st_q.mode),
        .sleep_i (sleep_i),
        .wake_i  (wake_i),
        .cfg_i   (cfg_q),
        .nxt_o   (nxt_mode)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = nxt_mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode <= M_ACT_HI;
        end else begin
            st_q <= st_d;
        end
    end

    lpm_out_map u_map (
        .mode_i    (st_q.mode),
        .clk_sel_o (clk_sel_o),
        .halted_o  (halted_o)
    );

    assign mode_o       = st_q.mode;
    assign nfilt_fast_o = cfg_q.nfilt_fast;

endmodule

// File: rtl/lpm_mode_ctrl_chk.sv
module lpm_mode_ctrl_chk
    import lpm_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sleep_i,
    input logic              wake_i,
    input logic [MODE_W-1:0] mode_o,
    input logic [CSEL_W-1:0] clk_sel_o,
    input logic              halted_o,
    input lpm_cfg_t          cfg
);

    logic is_active;
    assign is_active = (mode_o == M_ACT_HI) || (mode_o == M_ACT_MED);

    // R1
    reset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (mode_o == M_ACT_HI));

    // R12
    halted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halted_o && !wake_i) |=> $stable(mode_o));

    // R12
    run_wake_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halted_o && !sleep_i) |=> $stable(mode_o));

    // R2
    active_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_active && sleep_i && !cfg.direct_en) |=> halted_o);

    // R4
    hi_to_med_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == M_ACT_HI && sleep_i && cfg.direct_en && !cfg.deep_en
         && cfg.med_en && !cfg.sub_en) |=> (mode_o == M_ACT_MED));

    // R6
    to_subact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_active && sleep_i && cfg.direct_en && cfg.deep_en
         && cfg.wtimer_en && cfg.sub_en) |=> (mode_o == M_SUBACT));

    // R9
    sleep_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == M_SLEEP && wake_i) |=>
        (mode_o == ($past(cfg.med_en) ? M_ACT_MED : M_ACT_HI)));

    // R10
    subsleep_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == M_SUBSLEEP && wake_i) |=> (mode_o == M_SUBACT));

    // R11
    standby_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == M_STANDBY) |-> (clk_sel_o == CSEL_OFF && halted_o));

    // R11
    legal_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o <= M_WATCH);

endmodule

bind lpm_mode_ctrl lpm_mode_ctrl_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .wake_i    (wake_i),
    .mode_o    (mode_o),
    .clk_sel_o (clk_sel_o),
    .halted_o  (halted_o),
    .cfg       (cfg_q)
);

// File: tb/lpm_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_mode_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wd = '0;
    logic       sleep = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] mode;
    logic [1:0] csel;
    logic       halted;
    logic       nfilt;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    started = 1'b0;

    // behavioural reference state
    int       m_mode = 0;
    bit [5:0] m_cfg = '0;

    always #4 clk = ~clk;

    lpm_mode_ctrl u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_wdata_i  (cfg_wd),
        .sleep_i      (sleep),
        .wake_i       (wake),
        .mode_o       (mode),
        .clk_sel_o    (csel),
        .halted_o     (halted),
        .nfilt_fast_o (nfilt)
    );

    function automatic int pick_speed(bit [5:0] c);
        return c[2] ? 1 : 0;
    endfunction

    function automatic int ref_next(int cur, bit s, bit w, bit [5:0] c);
        bit deep = c[0], sub = c[1], med = c[2], wt = c[3], dir = c[4];
        if (cur <= 1 && s) begin
            if (dir && cur == 0 && !deep && med && !sub) return 1;          // R4
            if (dir && cur == 1 && !deep && !med && !sub) return 0;         // R5
            if (dir && deep && wt && sub) return 2;                         // R6
            if (!deep) return 3;                                            // R2
            return wt ? 6 : 5;
        end
        if (cur == 2 && s) begin
            if (dir && deep && wt && !sub) return pick_speed(c);            // R7
            return deep ? 6 : 4;                                            // R3
        end
        if (w) begin
            if (cur == 3 || cur == 5) return pick_speed(c);                 // R9
            if (cur == 4) return 2;                                         // R10
            if (cur == 6) return sub ? 2 : pick_speed(c);
        end
        return cur;
    endfunction

    function automatic int ref_csel(int m);
        case (m)
            1: return 1;
            2, 4, 6: return 2;
            5: return 3;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 0;
            m_cfg  <= '0;
        end else begin
            m_mode <= ref_next(m_mode, sleep, wake, m_cfg);
            if (cfg_we) m_cfg <= cfg_wd;
        end
        started <= 1'b1;
    end

    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (int'(mode) != m_mode) begin
                n_bad++;
                $display("FAIL %s mode: got %0d expected %0d", tag, mode, m_mode);
            end
            n_chk++;
            if (int'(csel) != ref_csel(m_mode)) begin
                n_bad++;
                $display("FAIL R11 clk_sel: got %0d expected %0d", csel, ref_csel(m_mode));
            end
            n_chk++;
            if (halted != (m_mode >= 3)) begin
                n_bad++;
                $display("FAIL R11 halted: got %0b expected %0b", halted, (m_mode >= 3));
            end
            n_chk++;
            if (nfilt != m_cfg[5]) begin
                n_bad++;
                $display("FAIL %s nfilt: got %0b expected %0b", tag, nfilt, m_cfg[5]);
            end
        end
    end

    task automatic step(input bit s, input bit w, input bit we, input bit [5:0] d);
        sleep  = s;
        wake   = w;
        cfg_we = we;
        cfg_wd = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 6'h00);
    endtask

    task automatic wr(input bit [5:0] d);
        step(1'b0, 1'b0, 1'b1, d);
    endtask

    task automatic slp();
        step(1'b1, 1'b0, 1'b0, 6'h00);
    endtask

    task automatic wk();
        step(1'b0, 1'b1, 1'b0, 6'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        tag = "R1";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();

        // R2 halting choices from full speed
        tag = "R2";
        wr(6'h00); slp(); idle(); wk(); idle();
        wr(6'h01); slp(); idle(); wk();
        wr(6'h09); slp(); idle(); wk();

        // R9 speed flag picks resume mode
        tag = "R9";
        wr(6'h04); slp(); wk(); idle();
        wr(6'h05); slp(); wk(); idle();

        // R5 medium to full, R4 full to medium
        tag = "R5";
        wr(6'h10); slp(); idle();
        tag = "R4";
        wr(6'h14); slp(); idle();

        // R6 active to subclock-active
        tag = "R6";
        wr(6'h1B); slp(); idle();

        // R7 subclock-active back to each active speed
        tag = "R7";
        wr(6'h19); slp(); idle();
        wr(6'h1B); slp();
        wr(6'h1D); slp(); idle();
        wr(6'h1B); slp(); idle();

        // R3 halting from subclock-active, R10 wakes
        tag = "R3";
        wr(6'h02); slp(); idle();
        tag = "R10";
        wk(); idle();
        tag = "R3";
        wr(6'h03); slp();
        tag = "R10";
        wk(); idle();
        tag = "R3";
        wr(6'h0B); slp();
        tag = "R10";
        wr(6'h0D); wk(); idle();

        // R8 unmatched direct combinations fall back
        tag = "R8";
        wr(6'h11); slp(); wk();
        wr(6'h16); slp(); wk();
        wr(6'h1B); slp(); idle();
        wr(6'h12); slp(); wk();
        wr(6'h19); slp(); idle();

        // R12 ignored events and precedence
        tag = "R12";
        wr(6'h00); wk(); wk();
        slp(); slp(); slp();
        wk(); idle();
        step(1'b1, 1'b1, 1'b0, 6'h00); idle();
        step(1'b1, 1'b1, 1'b0, 6'h00);

        // R13 write timing and noise-filter bit
        tag = "R13";
        wr(6'h00); step(1'b1, 1'b0, 1'b1, 6'h14); wk(); idle();
        wr(6'h20); idle();
        step(1'b1, 1'b0, 1'b1, 6'h01); wk(); idle();
        wr(6'h00); idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule